// File: doc/BRIEF.md
# Page-Mode DRAM Address Sequencer

This block sits between a CPU-side request port and a DRAM that takes its address in two halves over one narrow bus. The row and column halves are told apart by two active-low strobes. A full-width address is split into an upper half, the row, and a lower half, the column. The row is presented while the row strobe falls, and the column is presented while the column strobe falls. Read data is captured at the end of the column phase. Write data is driven onto the data lines for as long as the column strobe is low.

After an access the row strobe stays low, so the row remains open. A later request to the same row skips the row phase entirely and reissues only a column phase; this is page mode. A request to a different row first raises the row strobe for a precharge interval, then opens the new row. The precharge, row-to-column and column durations are parameters counted in clock cycles. Refresh and analog timing are handled elsewhere.

Top module: `pgdram_ctrl`

## Requirements
- R1: While reset is high, and at the first cycle after it, both strobes and the write strobe read 1, `req_ready` reads 0 and `mem_wdata_oe` reads 0.
- R2: When the row strobe falls, `mem_addr` carries `req_addr[15:8]`. When the column strobe falls, `mem_addr` carries `req_addr[7:0]`. Together these select one cell of a 256 x 256 array.
- R3: The column strobe is never low while the row strobe is high.
- R4: The first request after reset opens its row. The row strobe falls, stays low T_RCD cycles, and then the column strobe is low for exactly T_CAS cycles. `req_ready` appears T_RCD+T_CAS edges after the accepting edge.
- R5: A request whose row equals the open row causes no row-strobe edge. `req_ready` appears T_CAS edges after the accepting edge.
- R6: A request to a different row raises the row strobe for at least T_RP cycles (exactly T_RP), then opens the new row. `req_ready` appears T_RP+T_RCD+T_CAS edges after the accepting edge.
- R7: For a read (`req_write`=0), `req_rdata` equals the byte last written to that address (0 if it was never written) in the cycle `req_ready` is high.
- R8: For a write (`req_write`=1), `mem_we_n` is low only while the column strobe is low. `mem_wdata` is driven with `mem_wdata_oe`=1, and a later read of that address returns the byte.
- R9: `req_ready` is a single-cycle pulse per request. It coincides with the column strobe returning high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; accepted when the sequencer is idle, held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address: row in [15:8], column in [7:0] |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 8 | Read data, valid with `req_ready` |
| mem_addr | output | 8 | Multiplexed row/column address |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_wdata | output | 8 | Data toward the DRAM |
| mem_wdata_oe | output | 1 | Drive enable for `mem_wdata` |
| mem_rdata | input | 8 | Data from the DRAM |

## Verification
Two decisions can fall into the same cycle. The first is the completion of one access. The second is the open-row comparison for the next request, which is needed when a new request waits at the port as `req_ready` fires. The bench provokes this by keeping `req_valid` high through the ready cycle and swapping address and data at once. It does this for a page hit, for a row miss that must precharge, and for a return to an old row. Each outcome is judged by the edge count to `req_ready` and by the count of row-strobe falls. It is also judged by the row and column the behavioural DRAM latched, and by the data returned.

// File: rtl/pgdram_pkg.sv
package pgdram_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_RAS  = 2'd2,
    ST_CAS  = 2'd3
  } seq_st_e;
endpackage

// File: rtl/pgdram_timer.sv
// Loadable down-counter: a phase of D cycles loads D and lasts until expiry.
module pgdram_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] dur,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= dur - CNT_W'(1);
    else if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/pgdram_row_track.sv
// Remembers which row is held open and compares an incoming row against it.
module pgdram_row_track #(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic [ROW_W-1:0] new_row,
  output logic             row_open,
  output logic             row_hit
);
  logic [ROW_W-1:0] row_q;
  logic             open_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q  <= '0;
      open_q <= 1'b0;
    end else if (capture) begin
      row_q  <= new_row;
      open_q <= 1'b1;
    end
  end

  assign row_open = open_q;
  assign row_hit  = open_q && (row_q == new_row);
endmodule

// File: rtl/pgdram_addr_split.sv
// Splits a flat address into row and column words padded to the bus width.
module pgdram_addr_split #(
  parameter int ROW_W = 8,
  parameter int COL_W = 8,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int BUS_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BUS_W-1:0]  row_bus,
  output logic [BUS_W-1:0]  col_bus
);
  generate
    if (ROW_W == BUS_W) begin : g_row_full
      assign row_bus = addr[ADDR_W-1:COL_W];
    end else begin : g_row_pad
      assign row_bus = {{(BUS_W-ROW_W){1'b0}}, addr[ADDR_W-1:COL_W]};
    end
    if (COL_W == BUS_W) begin : g_col_full
      assign col_bus = addr[COL_W-1:0];
    end else begin : g_col_pad
      assign col_bus = {{(BUS_W-COL_W){1'b0}}, addr[COL_W-1:0]};
    end
  endgenerate
endmodule

// File: rtl/pgdram_seq.sv
// Phase sequencer: idle, precharge, row open, column access.
module pgdram_seq
  import pgdram_pkg::*;
#(
  parameter int T_RP  = 2,
  parameter int T_RCD = 2,
  parameter int T_CAS = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             row_open,
  input  logic             row_hit,
  input  logic             tmr_exp,
  output seq_st_e          nxt_st,
  output logic             accept,
  output logic             finish,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_dur
);
  seq_st_e st_q;

  always_comb begin
    nxt_st   = st_q;
    accept   = 1'b0;
    finish   = 1'b0;
    tmr_load = 1'b0;
    tmr_dur  = CNT_W'(T_CAS);
    case (st_q)
      ST_IDLE: if (req_valid) begin
        accept   = 1'b1;
        tmr_load = 1'b1;
        if (row_hit) begin
          nxt_st  = ST_CAS;
          tmr_dur = CNT_W'(T_CAS);
        end else if (row_open) begin
          nxt_st  = ST_PRE;
          tmr_dur = CNT_W'(T_RP);
        end else begin
          nxt_st  = ST_RAS;
          tmr_dur = CNT_W'(T_RCD);
        end
      end
      ST_PRE: if (tmr_exp) begin
        nxt_st   = ST_RAS;
        tmr_load = 1'b1;
        tmr_dur  = CNT_W'(T_RCD);
      end
      ST_RAS: if (tmr_exp) begin
        nxt_st   = ST_CAS;
        tmr_load = 1'b1;
        tmr_dur  = CNT_W'(T_CAS);
      end
      ST_CAS: if (tmr_exp) begin
        nxt_st = ST_IDLE;
        finish = 1'b1;
      end
      default: nxt_st = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= nxt_st;
  end
endmodule

// File: rtl/pgdram_ctrl.sv
module pgdram_ctrl
  import pgdram_pkg::*;
#(
  parameter int ROW_W  = 8,
  parameter int COL_W  = 8,
  parameter int DATA_W = 8,
  parameter int T_RP   = 2,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 2,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int BUS_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] req_rdata,
  output logic [BUS_W-1:0]  mem_addr,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_wdata_oe,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int T_MAX0 = (T_RP > T_RCD) ? T_RP : T_RCD;
  localparam int T_MAX  = (T_MAX0 > T_CAS) ? T_MAX0 : T_CAS;
  localparam int CNT_W  = $clog2(T_MAX + 1);

  logic [ADDR_W-1:0] addr_q, addr_cur;
  logic              wr_q, wr_cur;
  logic [DATA_W-1:0] wdata_q, wdata_cur;
  logic [BUS_W-1:0]  row_bus, col_bus;
  logic              accept, finish, tmr_load, tmr_exp, row_open, row_hit;
  logic [CNT_W-1:0]  tmr_dur;
  seq_st_e           nxt_st;

  // On the accepting edge the outputs already need the new request.
  assign addr_cur  = accept ? req_addr  : addr_q;
  assign wr_cur    = accept ? req_write : wr_q;
  assign wdata_cur = accept ? req_wdata : wdata_q;

  pgdram_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W)) u_split (
    .addr    (addr_cur),
    .row_bus (row_bus),
    .col_bus (col_bus)
  );

  pgdram_row_track #(.ROW_W(ROW_W)) u_rows (
    .clk      (clk),
    .rst      (rst),
    .capture  (accept),
    .new_row  (req_addr[ADDR_W-1:COL_W]),
    .row_open (row_open),
    .row_hit  (row_hit)
  );

  pgdram_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .dur     (tmr_dur),
    .expired (tmr_exp)
  );

  pgdram_seq #(.T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .row_open  (row_open),
    .row_hit   (row_hit),
    .tmr_exp   (tmr_exp),
    .nxt_st    (nxt_st),
    .accept    (accept),
    .finish    (finish),
    .tmr_load  (tmr_load),
    .tmr_dur   (tmr_dur)
  );

  // All DRAM-side outputs are registered, decoded from the next phase.
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q       <= '0;
      wr_q         <= 1'b0;
      wdata_q      <= '0;
      mem_addr     <= '0;
      mem_ras_n    <= 1'b1;
      mem_cas_n    <= 1'b1;
      mem_we_n     <= 1'b1;
      mem_wdata    <= '0;
      mem_wdata_oe <= 1'b0;
      req_ready    <= 1'b0;
      req_rdata    <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wr_q    <= req_write;
        wdata_q <= req_wdata;
      end
      mem_ras_n    <= (nxt_st == ST_PRE) || ((nxt_st == ST_IDLE) && !row_open);
      mem_cas_n    <= (nxt_st != ST_CAS);
      mem_we_n     <= !((nxt_st == ST_CAS) && wr_cur);
      mem_wdata_oe <= (nxt_st == ST_CAS) && wr_cur;
      mem_wdata    <= wdata_cur;
      mem_addr     <= (nxt_st == ST_CAS) ? col_bus : row_bus;
      req_ready    <= finish;
      if (finish && !wr_q) req_rdata <= mem_rdata;
    end
  end
endmodule

// File: rtl/pgdram_ctrl_chk.sv
module pgdram_ctrl_chk #(
  parameter int T_RP  = 2,
  parameter int T_CAS = 2
) (
  input logic clk,
  input logic rst,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic ready
);
  logic [15:0] cas_lo, ras_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      cas_lo <= '0;
      ras_hi <= '1;
    end else begin
      cas_lo <= cas_n ? 16'd0 : cas_lo + 16'd1;
      if (!ras_n)             ras_hi <= '0;
      else if (ras_hi != '1) ras_hi <= ras_hi + 16'd1;
    end
  end

  AST_CAS_NEEDS_RAS: assert property (@(posedge clk) disable iff (rst) !cas_n |-> !ras_n); // R3
  AST_CAS_WIDTH: assert property (@(posedge clk) disable iff (rst) $rose(cas_n) |-> cas_lo == 16'(T_CAS)); // R4
  AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (rst) $fell(ras_n) |-> ras_hi >= 16'(T_RP)); // R6
  AST_WE_INSIDE_CAS: assert property (@(posedge clk) disable iff (rst) !we_n |-> !cas_n); // R8
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst) ready |=> !ready); // R9
  AST_READY_AT_CAS_END: assert property (@(posedge clk) disable iff (rst) ready |-> $rose(cas_n)); // R9
endmodule

bind pgdram_ctrl pgdram_ctrl_chk #(.T_RP(T_RP), .T_CAS(T_CAS)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .ras_n (mem_ras_n),
  .cas_n (mem_cas_n),
  .we_n  (mem_we_n),
  .ready (req_ready)
);

// File: tb/pgdram_ctrl_test.sv
module pgdram_ctrl_test;
  localparam int RP = 3, RCD = 2, CAS = 2;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready;
  logic [7:0] req_rdata, mem_addr, mem_wdata;
  logic [7:0] mem_rdata = '0;
  logic mem_ras_n, mem_cas_n, mem_we_n, mem_wdata_oe;

  always #2 clk = ~clk;

  pgdram_ctrl #(.T_RP(RP), .T_RCD(RCD), .T_CAS(CAS)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .req_rdata(req_rdata), .mem_addr(mem_addr), .mem_ras_n(mem_ras_n),
    .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n), .mem_wdata(mem_wdata),
    .mem_wdata_oe(mem_wdata_oe), .mem_rdata(mem_rdata)
  );

  int total = 0, bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct {
    bit          wr;
    logic [15:0] addr;
    logic [7:0]  data;
    int          lat;
    int          falls;
    int          start;
    int          kind;   // 4 cold, 5 hit, 6 miss
  } exp_t;
  exp_t q[$];

  // Behavioural DRAM model plus monitor, sampled at the falling edge.
  logic [7:0] dmem [int];
  logic [7:0] row_l = '0, col_l = '0, last_wd = '0;
  logic prev_ras = 1, prev_cas = 1, prev_rdy = 0, last_oe = 0;
  int ras_falls = 0, strobe_bad = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_ras && !mem_ras_n) begin row_l = mem_addr; ras_falls++; end
      if (prev_cas && !mem_cas_n) begin
        col_l = mem_addr;
        if (!mem_we_n) begin
          dmem[{row_l, col_l}] = mem_wdata;
          last_wd = mem_wdata;
          last_oe = mem_wdata_oe;
        end
      end
      if (!mem_cas_n && mem_we_n)
        mem_rdata = dmem.exists({row_l, col_l}) ? dmem[{row_l, col_l}] : 8'h00;
      if (!mem_cas_n && mem_ras_n) strobe_bad++;
      if (req_ready) begin
        exp_t it;
        chk(!prev_rdy, "R9", "ready longer than one cycle", 1, 0);
        if (q.size() == 0) chk(0, "R9", "ready without request", 1, 0);
        else begin
          it = q.pop_front();
          chk(row_l == it.addr[15:8], "R2", "row latched", row_l, it.addr[15:8]);
          chk(col_l == it.addr[7:0], "R2", "column latched", col_l, it.addr[7:0]);
          case (it.kind)
            4: chk(cyc - it.start == it.lat, "R4", "cold latency", cyc - it.start, it.lat);
            5: chk(cyc - it.start == it.lat, "R5", "hit latency", cyc - it.start, it.lat);
            default: chk(cyc - it.start == it.lat, "R6", "miss latency", cyc - it.start, it.lat);
          endcase
          if (it.kind == 5) chk(ras_falls == it.falls, "R5", "row strobe fell on hit", ras_falls, it.falls);
          else chk(ras_falls == it.falls, "R6", "row opens", ras_falls, it.falls);
          if (it.wr) begin
            chk(last_wd == it.data, "R8", "write data", last_wd, it.data);
            chk(last_oe, "R8", "drive enable", last_oe, 1);
          end else
            chk(req_rdata == it.data, "R7", "read data", req_rdata, it.data);
        end
      end
      prev_rdy = req_ready;
    end
    prev_ras = mem_ras_n;
    prev_cas = mem_cas_n;
  end

  // Driver with its own reference of the requirements.
  logic [7:0] refm [int];
  bit b_open = 0;
  logic [7:0] b_row = '0;
  int b_falls = 0;

  task automatic issue(input bit wr, input logic [15:0] a, input logic [7:0] d, input bit keep);
    exp_t it;
    int w;
    it.wr = wr; it.addr = a;
    it.data = wr ? d : (refm.exists(int'(a)) ? refm[int'(a)] : 8'h00);
    if (wr) refm[int'(a)] = d;
    if (!b_open) begin it.kind = 4; it.lat = 1 + RCD + CAS; b_falls++; end
    else if (b_row != a[15:8]) begin it.kind = 6; it.lat = 1 + RP + RCD + CAS; b_falls++; end
    else begin it.kind = 5; it.lat = 1 + CAS; end
    b_open = 1; b_row = a[15:8];
    it.falls = b_falls;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    it.start = cyc;
    q.push_back(it);
    w = 0;
    do begin @(negedge clk); w++; end while (!req_ready && w < 200);
    if (w >= 200) chk(0, "R9", "no ready", 0, 1);
    if (!keep) begin
      req_valid = 0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(0, "R9", "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_ras_n && mem_cas_n && mem_we_n, "R1", "strobes in reset", {mem_ras_n, mem_cas_n, mem_we_n}, 7);
    chk(!req_ready && !mem_wdata_oe, "R1", "ready/oe in reset", {req_ready, mem_wdata_oe}, 0);
    rst = 0;
    @(negedge clk);
    chk(mem_ras_n && mem_cas_n, "R1", "strobes after reset", {mem_ras_n, mem_cas_n}, 3);
    issue(1, 16'h1234, 8'hA5, 0);   // R4 cold open
    issue(0, 16'h1234, 8'h00, 0);   // R5 hit read
    issue(1, 16'h1299, 8'h3C, 0);   // R5 hit write
    issue(0, 16'h5612, 8'h00, 1);   // R6 miss, unwritten
    issue(1, 16'h5634, 8'h77, 1);   // back-to-back hit
    issue(0, 16'h1299, 8'h00, 1);   // back-to-back miss
    issue(0, 16'h1234, 8'h00, 0);   // hit after miss
    issue(1, 16'h3412, 8'h12, 0);   // R2 swapped halves
    issue(1, 16'h1234, 8'hE1, 0);
    issue(0, 16'h3412, 8'h00, 0);
    for (int i = 0; i < 6; i++) issue(1, {8'(i * 37), 8'(i * 11)}, 8'(i + 1), 0);
    for (int i = 0; i < 6; i++) issue(0, {8'(i * 37), 8'(i * 11)}, 8'h00, i[0]);
    req_valid = 0;
    repeat (4) @(negedge clk);
    chk(strobe_bad == 0, "R3", "column low with row high", strobe_bad, 0);
    chk(q.size() == 0, "R9", "outstanding requests", q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule